// File: doc/BRIEF.md
# Numeric Coprocessor Link Controller

This block sits between a CPU and a numeric coprocessor and provides the glue logic that ties them together. It decodes the I/O address to produce the coprocessor's chip select. It relays the coprocessor's busy indication to the CPU. It captures coprocessor faults and turns them into an interrupt request. It also produces a reset for the coprocessor.

While the coprocessor works normally, its active-low busy signal reaches the CPU one clock later. If the coprocessor raises its active-low error line during a busy period, the controller latches two things: the CPU busy line stays held active, and an interrupt request is raised. Software clears both by writing to either of two clear ports. A write to the second of those ports also pulses the coprocessor reset for a fixed number of clocks. A synchronous system reset clears the latch and holds the coprocessor reset active.

All outputs are registered. Every input is sampled on the rising clock edge, and its effect appears at the outputs one cycle later.

Top module: `cop_link_ctrl`

## Requirements
- R1: `cop_sel` is 1 in the cycle after `io_addr` lies in 0x0F8..0x0FF, and 0 after any other address, including addresses whose upper bits are non-zero. This holds whatever the value of `io_wr`.
- R2: With no fault latched, `cpu_busy_n` equals the value `cop_busy_n` had one cycle earlier.
- R3: If `cop_err_n` and `cop_busy_n` are both 0 in the same cycle, then from the next cycle `irq` is 1 and `cpu_busy_n` is 0, whatever `cop_busy_n` does afterwards.
- R4: If `cop_err_n` is 0 while `cop_busy_n` is 1, nothing is latched: `irq` stays 0 and `cpu_busy_n` stays 1.
- R5: A cycle with `io_wr`=1 and `io_addr` equal to 0x0F0 or 0x0F1 clears the latch. In the next cycle `irq` is 0 and `cpu_busy_n` again follows `cop_busy_n`. If a new fault condition is present in that same cycle, the set wins.
- R6: A latched fault is not cleared by a write to any other address, nor by 0x0F0 or 0x0F1 presented with `io_wr`=0.
- R7: While `rst` is 1, the outputs in the next cycle are `irq`=0, `cpu_busy_n`=1, `cop_sel`=0 and `cop_rst`=1. Any latched fault is lost.
- R8: A cycle with `io_wr`=1 and `io_addr`=0x0F1 drives `cop_rst` to 1 for exactly RST_CYC cycles (default 6, minimum 4), starting the next cycle. A write to 0x0F0 does not drive `cop_rst`.
- R9: A further write to 0x0F1 while the pulse is running restarts the full RST_CYC count from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| io_addr | input | ADDR_W (10) | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| cop_busy_n | input | 1 | Coprocessor busy, active low |
| cop_err_n | input | 1 | Coprocessor error, active low |
| cop_sel | output | 1 | Coprocessor chip select, active high |
| cpu_busy_n | output | 1 | Busy to the CPU, active low |
| irq | output | 1 | Coprocessor error interrupt request |
| cop_rst | output | 1 | Coprocessor reset, active high |

## Verification
The hardest situations to reach are a fault being set and cleared in the same cycle, and a reset write arriving partway through a running reset pulse. Directed sequences line up an error-while-busy cycle with a write to the clear port. They also issue a second write to 0x0F1 three cycles into a pulse. A seeded random phase then mixes busy, error and writes to the clear and reset ports. A behavioural model, compared every cycle, catches any difference in ordering.

// File: rtl/cop_link_pkg.sv
package cop_link_pkg;

  // True when the upper address bits match the window base, i.e. the address
  // lies inside an aligned window of 2**span_log2 ports.
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int unsigned span_log2);
    logic [15:0] mask;
    mask = 16'hFFFF << span_log2;
    return (addr & mask) == (base & mask);
  endfunction

endpackage

// File: rtl/cop_addr_dec.sv
module cop_addr_dec #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned SEL_LOG2  = 3,
  parameter logic [ADDR_W-1:0] SEL_BASE = 'h0F8,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h0F0,
  parameter logic [ADDR_W-1:0] RST_PORT = 'h0F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              sel_q,
  output logic              clr_hit,
  output logic              rst_hit
);
  import cop_link_pkg::*;

  localparam int unsigned PAD_W = 16 - ADDR_W;

  logic sel_d;

  always_comb begin
    sel_d   = in_window({{PAD_W{1'b0}}, addr}, {{PAD_W{1'b0}}, SEL_BASE}, SEL_LOG2);
    rst_hit = wr && (addr == RST_PORT);
    clr_hit = wr && ((addr == CLR_PORT) || (addr == RST_PORT));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= sel_d;
  end

  // R5/R8: any reset-port write is also a clear-port write
  a_r5_rst_port_clears: assert property (@(posedge clk) disable iff (rst)
    rst_hit |-> clr_hit);
  // R7: chip select low after reset
  a_r7_sel_reset: assert property (@(posedge clk) rst |=> !sel_q);

endmodule

// File: rtl/cop_err_latch.sv
module cop_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic busy_n_in,
  input  logic err_n_in,
  input  logic clr,
  output logic cpu_busy_n,
  output logic irq
);
  logic fault_q;
  logic fault_d;
  logic set_c;

  always_comb begin
    set_c   = !err_n_in && !busy_n_in;
    fault_d = set_c || (fault_q && !clr);   // set has priority over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q    <= 1'b0;
      cpu_busy_n <= 1'b1;
    end else begin
      fault_q    <= fault_d;
      cpu_busy_n <= busy_n_in && !fault_d;
    end
  end

  assign irq = fault_q;

  a_r3_fault_sets: assert property (@(posedge clk) disable iff (rst)
    (!err_n_in && !busy_n_in) |=> (irq && !cpu_busy_n));
  a_r4_idle_err_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_n_in && !irq) |=> !irq);
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !(!err_n_in && !busy_n_in)) |=> !irq);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);
  a_r3_irq_implies_busy: assert property (@(posedge clk) disable iff (rst)
    irq |-> !cpu_busy_n);
  a_r7_latch_reset: assert property (@(posedge clk)
    rst |=> (!irq && cpu_busy_n));

endmodule

// File: rtl/cop_rst_pulse.sv
module cop_rst_pulse #(
  parameter int unsigned RST_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic cop_rst
);
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cop_rst <= 1'b1;
    end else if (kick) begin
      cnt_q   <= LOAD;
      cop_rst <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
      cop_rst <= 1'b1;
    end else begin
      cop_rst <= 1'b0;
    end
  end

  // Independent run-length counter for the checks below
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !cop_rst || kick) run_q <= '0;
    else                         run_q <= run_q + 1'b1;
  end

  a_r8_kick_starts: assert property (@(posedge clk) disable iff (rst)
    kick |=> cop_rst);
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
    cop_rst |-> (run_q < (CNT_W+1)'(RST_CYC)));
  a_r7_rst_holds: assert property (@(posedge clk) rst |=> cop_rst);

endmodule

// File: rtl/cop_link_ctrl.sv
module cop_link_ctrl #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned SEL_LOG2 = 3,
  parameter logic [ADDR_W-1:0] SEL_BASE = 'h0F8,
  parameter logic [ADDR_W-1:0] CLR_PORT = 'h0F0,
  parameter logic [ADDR_W-1:0] RST_PORT = 'h0F1,
  parameter int unsigned RST_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              cop_busy_n,
  input  logic              cop_err_n,
  output logic              cop_sel,
  output logic              cpu_busy_n,
  output logic              irq,
  output logic              cop_rst
);
  logic clr_hit;
  logic rst_hit;

  cop_addr_dec #(
    .ADDR_W(ADDR_W), .SEL_LOG2(SEL_LOG2), .SEL_BASE(SEL_BASE),
    .CLR_PORT(CLR_PORT), .RST_PORT(RST_PORT)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(io_addr), .wr(io_wr),
    .sel_q(cop_sel), .clr_hit(clr_hit), .rst_hit(rst_hit)
  );

  cop_err_latch u_lat (
    .clk(clk), .rst(rst), .busy_n_in(cop_busy_n), .err_n_in(cop_err_n),
    .clr(clr_hit), .cpu_busy_n(cpu_busy_n), .irq(irq)
  );

  cop_rst_pulse #(.RST_CYC(RST_CYC)) u_pls (
    .clk(clk), .rst(rst), .kick(rst_hit), .cop_rst(cop_rst)
  );

  // R8: a write to the clear-only port must not start a reset pulse
  a_r8_clr_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == CLR_PORT && !cop_rst) |=> !cop_rst);

endmodule

// File: tb/sim_cop_link_ctrl.sv
`timescale 1ns/1ps
module sim_cop_link_ctrl;
  localparam int RST_CYC = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic       cop_busy_n = 1'b1;
  logic       cop_err_n = 1'b1;
  logic       cop_sel, cpu_busy_n, irq, cop_rst;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R7";
  bit started = 0;
  bit done = 0;

  // reference model state
  bit m_latch, e_sel, e_bsy_n, e_irq, e_rst;
  int m_cnt;

  always #2 clk = ~clk;

  cop_link_ctrl #(.RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
    .cop_busy_n(cop_busy_n), .cop_err_n(cop_err_n),
    .cop_sel(cop_sel), .cpu_busy_n(cpu_busy_n), .irq(irq), .cop_rst(cop_rst)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_latch = 0; m_cnt = 0;
      e_sel = 0; e_bsy_n = 1; e_irq = 0; e_rst = 1;
    end else begin
      m_latch = (!cop_err_n && !cop_busy_n) ||
                (m_latch && !(io_wr && (io_addr == 10'h0F0 || io_addr == 10'h0F1)));
      e_irq   = m_latch;
      e_bsy_n = cop_busy_n && !m_latch;
      e_sel   = (io_addr >= 10'h0F8) && (io_addr <= 10'h0FF);
      if (io_wr && io_addr == 10'h0F1) begin m_cnt = RST_CYC - 1; e_rst = 1; end
      else if (m_cnt > 0) begin m_cnt--; e_rst = 1; end
      else e_rst = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(tag, "cop_sel", cop_sel, e_sel);
      chk(tag, "cpu_busy_n", cpu_busy_n, e_bsy_n);
      chk(tag, "irq", irq, e_irq);
      chk(tag, "cop_rst", cop_rst, e_rst);
    end
  end

  task automatic step(input logic [9:0] a, input logic w, input logic b_n, input logic e_n);
    @(negedge clk);
    io_addr = a; io_wr = w; cop_busy_n = b_n; cop_err_n = e_n;
  endtask

  task automatic idle(input logic b_n);
    step(10'h000, 1'b0, b_n, 1'b1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired in phase %s", tag);
    finish_run();
  end

  initial begin
    int pulse;
    repeat (3) @(negedge clk);
    // R7 reset state checked by model compare while rst high
    chk("R7", "cop_rst in reset", cop_rst, 1'b1);
    chk("R7", "irq in reset", irq, 1'b0);
    @(negedge clk); rst = 0;

    tag = "R1";
    for (int a = 10'h0E0; a <= 10'h10F; a++) step(10'(a), a[0], 1'b1, 1'b1);
    step(10'h2F8, 1'b0, 1'b1, 1'b1);
    step(10'h3FF, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    @(negedge clk); chk("R1", "sel after 0x000", cop_sel, 1'b0);

    tag = "R2";
    for (int i = 0; i < 8; i++) idle(i[0]);
    idle(1'b1);

    tag = "R3";
    step(10'h000, 1'b0, 1'b0, 1'b1);
    step(10'h000, 1'b0, 1'b0, 1'b0);
    idle(1'b1); idle(1'b1);
    chk("R3", "irq latched", irq, 1'b1);
    chk("R3", "busy held", cpu_busy_n, 1'b0);

    tag = "R6";
    step(10'h0F2, 1'b1, 1'b1, 1'b1);
    step(10'h0F0, 1'b0, 1'b1, 1'b1);
    step(10'h0F1, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    chk("R6", "irq not cleared", irq, 1'b1);

    tag = "R5";
    step(10'h0F0, 1'b1, 1'b1, 1'b1);
    idle(1'b1);
    chk("R5", "irq cleared by 0x0F0", irq, 1'b0);
    chk("R8", "no pulse from 0x0F0", cop_rst, 1'b0);
    // set and clear in one cycle: set wins
    step(10'h000, 1'b0, 1'b0, 1'b0);
    step(10'h0F0, 1'b1, 1'b0, 1'b0);
    idle(1'b1);
    chk("R5", "set beats clear", irq, 1'b1);

    tag = "R8";
    step(10'h0F1, 1'b1, 1'b1, 1'b1);
    pulse = 0;
    for (int i = 0; i < 10; i++) begin
      idle(1'b1);
      if (cop_rst) pulse++;
    end
    n_tests++;
    if (pulse != RST_CYC) begin
      n_fail++;
      $display("FAIL R8 pulse length actual=%0d expected=%0d", pulse, RST_CYC);
    end
    chk("R5", "irq cleared by 0x0F1", irq, 1'b0);

    tag = "R4";
    step(10'h000, 1'b0, 1'b1, 1'b0);
    step(10'h000, 1'b0, 1'b1, 1'b0);
    idle(1'b1);
    chk("R4", "no latch when idle", irq, 1'b0);
    chk("R4", "busy stays high", cpu_busy_n, 1'b1);

    tag = "R9";
    step(10'h0F1, 1'b1, 1'b1, 1'b1);
    idle(1'b1); idle(1'b1);
    step(10'h0F1, 1'b1, 1'b1, 1'b1);
    pulse = 0;
    for (int i = 0; i < 12; i++) begin
      idle(1'b1);
      if (cop_rst) pulse++;
    end
    n_tests++;
    if (pulse != RST_CYC) begin
      n_fail++;
      $display("FAIL R9 restarted pulse actual=%0d expected=%0d", pulse, RST_CYC);
    end

    tag = "R7";
    step(10'h000, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    rst = 1;
    idle(1'b0); idle(1'b0);
    chk("R7", "irq cleared by reset", irq, 1'b0);
    chk("R7", "busy released in reset", cpu_busy_n, 1'b1);
    chk("R7", "cop_rst in reset", cop_rst, 1'b1);
    rst = 0;
    idle(1'b1);

    tag = "R2/R3/R5 random";
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] a;
      int r;
      r = $urandom_range(0, 7);
      a = (r == 0) ? 10'h0F0 : (r == 1) ? 10'h0F1 : (r == 2) ? 10'h0FC : 10'($urandom);
      step(a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 0), ($urandom_range(0, 5) != 0));
    end
    idle(1'b1); idle(1'b1);
    finish_run();
  end
endmodule